// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block holds the working state of one direct-memory-access channel: a current memory address, a remaining transfer count, copies of both as last programmed, and two control bits (channel enable and auto-reload). A host programs these through a single-cycle write port. An arbiter outside the block pulses a transfer strobe each time the channel moves one byte. On each accepted strobe, the unit moves the address up by one and the remaining count down by one.

The count is programmed as the number of transfers minus one, so the final transfer of a block is the one where the count reads zero. During that transfer the unit raises a terminal-count flag. It raises a mark flag on any transfer that leaves the remaining count at a multiple of 128, which gives the peripheral a regular timing signal. After the final transfer, the channel does one of two things. If auto-reload is set, it restores the programmed address and count and stays enabled. If not, it disables itself and stops requesting.

Top module: `dma_chan_unit`

## Requirements
- R1: After reset, req_o, auto_o, tc_o and mark_o are low, and addr_o and cnt_o are zero.
- R2: A host write (wr_en high) takes effect in the next cycle. With wr_sel=0 it loads wr_data[15:0] into both the current and the saved address. With wr_sel=1 it loads wr_data[13:0] into both the current and the saved count. With wr_sel=2 it loads the enable from wr_data[0] and the auto-reload from wr_data[1]. With wr_sel=3 it changes nothing.
- R3: A transfer is accepted when xfer_i is high, the channel is enabled and wr_en is low. An accepted transfer that does not reload raises addr_o by one, modulo 2^16, in the next cycle.
- R4: An accepted transfer with a nonzero count lowers cnt_o by one in the next cycle.
- R5: tc_o is high in exactly those cycles that carry an accepted transfer while cnt_o is zero.
- R6: mark_o is high in exactly those cycles that carry an accepted transfer while cnt_o is nonzero and cnt_o minus one is a multiple of 128.
- R7: Without auto-reload, the terminal-count transfer clears the enable, so req_o falls in the next cycle. cnt_o stays at zero and addr_o still advances by one.
- R8: With auto-reload, the terminal-count transfer restores the saved address and count in the next cycle, and req_o stays high.
- R9: When a host write and xfer_i occur in the same cycle, the write takes effect and the transfer is dropped: there is no step, no tc_o and no mark_o.
- R10: While the channel is disabled, xfer_i changes neither addr_o nor cnt_o and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 control, 3 none |
| wr_data | input | 16 | Host write data |
| xfer_i | input | 1 | One-byte transfer strobe from the arbiter |
| req_o | output | 1 | Channel enabled and requesting |
| auto_o | output | 1 | Auto-reload setting |
| addr_o | output | 16 | Current transfer address |
| cnt_o | output | 14 | Remaining count (transfers minus one) |
| tc_o | output | 1 | Terminal count, high during the final transfer |
| mark_o | output | 1 | High during a transfer that leaves the count at a multiple of 128 |

## Verification
The bench starts a block two transfers below the top of the address space. A unit whose address does not wrap, or whose terminal count fires one transfer early or late, then shows a wrong address or a misplaced tc_o. Mark is probed on both sides of a 128 boundary and on the transfer that leaves a count of zero. A decoder that tests the count before the step instead of after it fires one transfer off. The auto-reload path is run twice in a row, so a unit that lets the restored count drift, or that drops the enable, fails the second block. A host write is made in the same cycle as a strobe, including while the count reads zero. A design that let the strobe win would step the registers or raise tc_o.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // True when a step from count c lands on a multiple of 2**lg.
  function automatic logic mark_hit(input logic [31:0] c, input int unsigned lg);
    logic [31:0] nxt;
    logic [31:0] msk;
    nxt = c - 32'd1;
    msk = (32'd1 << lg) - 32'd1;
    return (c != 32'd0) && ((nxt & msk) == 32'd0);
  endfunction

endpackage

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chan_pkg::*;
#(
  parameter int CNT_W     = 14,
  parameter int MARK_LOG2 = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_i,
  input  logic             wr_en,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             last,
  output logic             tc,
  output logic             mark
);

  always_comb begin
    step = xfer_i & en & ~wr_en;
    last = (cnt == '0);
    tc   = step & last;
    mark = step & mark_hit(32'(cnt), MARK_LOG2);
  end

  // R6: after a mark the remaining count sits on an interval boundary
  a_r6_mark_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> (cnt[MARK_LOG2-1:0] == '0));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tc,
  output logic              en,
  output logic              auto_ld,
  output logic              ld_addr,
  output logic              ld_cnt,
  output logic [ADDR_W-1:0] save_addr,
  output logic [CNT_W-1:0]  save_cnt
);

  logic ld_ctrl;

  always_comb begin
    ld_addr = wr_en && (reg_sel_e'(wr_sel) == SEL_ADDR);
    ld_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_CNT);
    ld_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en        <= 1'b0;
      auto_ld   <= 1'b0;
      save_addr <= '0;
      save_cnt  <= '0;
    end else begin
      if (ld_addr) save_addr <= wr_data[ADDR_W-1:0];
      if (ld_cnt)  save_cnt  <= wr_data[CNT_W-1:0];
      if (ld_ctrl) begin
        en      <= wr_data[0];
        auto_ld <= wr_data[1];
      end else if (tc && !auto_ld) begin
        en <= 1'b0;
      end
    end
  end

  // R7: one-shot block drops the enable after its terminal transfer
  a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !auto_ld) |=> !en);

  // R8: repeating block keeps the channel enabled
  a_r8_repeat_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && auto_ld) |=> en);

endmodule

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ld_addr,
  input  logic              ld_cnt,
  input  logic              step,
  input  logic              last,
  input  logic              auto_ld,
  input  logic [ADDR_W-1:0] save_addr,
  input  logic [CNT_W-1:0]  save_cnt,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt
);

  logic reload;
  assign reload = step & last & auto_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
    end else begin
      if (ld_addr)     addr <= wr_data[ADDR_W-1:0];
      else if (reload) addr <= save_addr;
      else if (step)   addr <= addr + ADDR_W'(1);

      if (ld_cnt)               cnt <= wr_data[CNT_W-1:0];
      else if (reload)          cnt <= save_cnt;
      else if (step && !last)   cnt <= cnt - CNT_W'(1);
    end
  end

  // R3: address walks upward by one per accepted transfer
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reload) |=> addr == $past(addr) + ADDR_W'(1));

  // R4: count walks downward by one before the final transfer
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> cnt == $past(cnt) - CNT_W'(1));

  // R8: reload brings back the saved count
  a_r8_reload_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt == save_cnt) && (addr == save_addr));

  // R9: a host address write lands regardless of the strobe
  a_r9_host_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ld_addr |=> addr == $past(wr_data[ADDR_W-1:0]));

endmodule

// File: rtl/dma_chan_unit.sv
module dma_chan_unit #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 14,
  parameter int MARK_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer_i,
  output logic              req_o,
  output logic              auto_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              tc_o,
  output logic              mark_o
);

  logic              en, auto_ld, ld_addr, ld_cnt, step, last, tc, mark;
  logic [ADDR_W-1:0] save_addr, addr;
  logic [CNT_W-1:0]  save_cnt, cnt;

  dma_chan_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tc(tc), .en(en), .auto_ld(auto_ld), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .save_addr(save_addr), .save_cnt(save_cnt)
  );

  dma_chan_counter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .step(step), .last(last), .auto_ld(auto_ld), .save_addr(save_addr),
    .save_cnt(save_cnt), .addr(addr), .cnt(cnt)
  );

  dma_chan_flags #(.CNT_W(CNT_W), .MARK_LOG2(MARK_LOG2)) u_flags (
    .clk(clk), .rst_n(rst_n), .xfer_i(xfer_i), .wr_en(wr_en), .en(en), .cnt(cnt),
    .step(step), .last(last), .tc(tc), .mark(mark)
  );

  assign req_o  = en;
  assign auto_o = auto_ld;
  assign addr_o = addr;
  assign cnt_o  = cnt;
  assign tc_o   = tc;
  assign mark_o = mark;

  // R10: a disabled channel never flags a transfer
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(tc || mark));

endmodule

// File: tb/tb_dma_chan_unit.sv
module tb_dma_chan_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        xfer_i = 1'b0;
  logic        req_o, auto_o, tc_o, mark_o;
  logic [15:0] addr_o;
  logic [13:0] cnt_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dma_chan_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_i(xfer_i), .req_o(req_o), .auto_o(auto_o), .addr_o(addr_o),
    .cnt_o(cnt_o), .tc_o(tc_o), .mark_o(mark_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bench-side mark rule: step from c ends on a multiple of 128
  function automatic logic lands_on_mark(input int c);
    return (c != 0) && (((c - 1) % 128) == 0);
  endfunction

  task automatic host_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one strobe; checks flags mid-cycle and registers after the edge
  task automatic pulse(input string tag, input logic etc, input logic emk,
                       input logic [15:0] ea, input logic [13:0] ec, input logic ereq);
    @(negedge clk);
    xfer_i = 1'b1;
    #1;
    chk({tag, " tc"}, 32'(tc_o), 32'(etc));
    chk({tag, " mark"}, 32'(mark_o), 32'(emk));
    @(posedge clk);
    @(negedge clk);
    xfer_i = 1'b0;
    chk({tag, " addr"}, 32'(addr_o), 32'(ea));
    chk({tag, " cnt"}, 32'(cnt_o), 32'(ec));
    chk({tag, " req"}, 32'(req_o), 32'(ereq));
  endtask

  task automatic t_reset;
    chk("R1 req", 32'(req_o), 0);
    chk("R1 auto", 32'(auto_o), 0);
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 cnt", 32'(cnt_o), 0);
    chk("R1 tc", 32'(tc_o), 0);
    chk("R1 mark", 32'(mark_o), 0);
  endtask

  task automatic t_oneshot_wrap;
    host_wr(2'd0, 16'hFFFE);
    host_wr(2'd1, 16'd2);
    host_wr(2'd3, 16'h0003);          // R2: select 3 changes nothing
    chk("R2 sel3 req", 32'(req_o), 0);
    host_wr(2'd2, 16'h0001);
    chk("R2 addr", 32'(addr_o), 32'hFFFE);
    chk("R2 cnt", 32'(cnt_o), 2);
    chk("R2 req", 32'(req_o), 1);
    chk("R2 auto", 32'(auto_o), 0);
    pulse("R3 R4 first", 0, lands_on_mark(2), 16'hFFFF, 14'd1, 1);
    pulse("R3 R6 wrap", 0, lands_on_mark(1), 16'h0000, 14'd0, 1);
    pulse("R5 R7 final", 1, 0, 16'h0001, 14'd0, 0);
    pulse("R10 disabled", 0, 0, 16'h0001, 14'd0, 0);
  endtask

  task automatic t_mark;
    host_wr(2'd0, 16'h0400);
    host_wr(2'd1, 16'h0081);
    host_wr(2'd2, 16'h0001);
    pulse("R6 at 128", 0, lands_on_mark(129), 16'h0401, 14'h080, 1);
    pulse("R6 below 128", 0, lands_on_mark(128), 16'h0402, 14'h07F, 1);
  endtask

  task automatic t_host_wins;
    // write and strobe together: write lands, strobe dropped
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'h2222; xfer_i = 1'b1;
    #1;
    chk("R9 tc", 32'(tc_o), 0);
    chk("R9 mark", 32'(mark_o), 0);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; xfer_i = 1'b0;
    chk("R9 addr", 32'(addr_o), 32'h2222);
    chk("R9 cnt kept", 32'(cnt_o), 32'h07F);
    host_wr(2'd1, 16'd0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'd5; xfer_i = 1'b1;
    #1;
    chk("R9 tc at zero", 32'(tc_o), 0);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; xfer_i = 1'b0;
    chk("R9 cnt", 32'(cnt_o), 5);
    chk("R9 addr kept", 32'(addr_o), 32'h2222);
  endtask

  task automatic t_autoload;
    host_wr(2'd0, 16'h1000);
    host_wr(2'd1, 16'd1);
    host_wr(2'd2, 16'h0003);
    chk("R2 auto set", 32'(auto_o), 1);
    for (int blk = 0; blk < 2; blk++) begin
      pulse("R8 step", 0, 1, 16'h1001, 14'd0, 1);
      pulse("R8 reload", 1, 0, 16'h1000, 14'd1, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_oneshot_wrap();
    t_mark();
    t_host_wins();
    t_autoload();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule